// File: doc/BRIEF.md
# Serial Receiver with Error-Tagged FIFO

This block turns a serial line into stored words. On each baud tick it samples the line once. It recognises a frame made of a low start bit, eight data bits sent least significant first, one parity bit and a stop bit. When the stop bit arrives, it builds a 12-bit entry and pushes it into an eight-deep first-in first-out store. The entry holds the data byte, the received parity bit and three error flags. The flags report a bad stop bit, an all-zero break condition, and an overrun: a frame that arrived while the store was full.

A read command pops the oldest entry into two registered outputs that keep their value until the next read. The data output carries the parity bit and the byte. The error output carries the three flags. An empty flag tells the consumer that nothing is left to read. A ready flag tells the sender that another frame can be taken. When a frame completes while the store is full, the frame is dropped and its overrun is recorded on the newest stored entry. No separate status is kept for it.

Top module: `rx_err_fifo`

## Requirements
- R1: While `rst` is high, and in the cycle after it falls, `emptyFlag` is 1, `readyFlag` is 1, and `dataOut` and `errOut` are 0. Reset discards all stored entries.
- R2: The line is sampled only in cycles where `baudTick` is 1. A sampled 0 in idle starts a frame. The next eight samples are data bits, least significant bit first, then one parity sample, then one stop sample. On the stop sample the frame is stored, and a later read returns `dataOut[7:0]` = data and `dataOut[8]` = parity bit.
- R3: `errOut[0]` (frame error) is 1 for an entry whose stop sample was 0, and 0 otherwise.
- R4: `errOut[2]` (break) is 1 for an entry whose data bits, parity bit and stop sample were all 0. Such an entry also has `errOut[0]` = 1.
- R5: Entries are read oldest first, up to 8 stored at once. `dataOut` and `errOut` change only in the cycle after a read command given while not empty.
- R6: `readyFlag` is 0 exactly when 8 entries are stored. `emptyFlag` is 1 exactly when none are stored.
- R7: A frame that completes while 8 entries are stored, with no read in that cycle, is discarded. `errOut[1]` (overrun) becomes 1 on the newest stored entry. Every other entry reads with `errOut[1]` = 0.
- R8: A read command while `emptyFlag` is 1 leaves `dataOut`, `errOut`, `emptyFlag` and `readyFlag` unchanged.
- R9: If a frame completes in the same cycle as a read on a full store, the read frees a slot and the frame is stored without an overrun mark.
- R10: Line changes in cycles without `baudTick`, and ticks that sample a 1 while idle, store nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| baudTick | input | 1 | One-cycle pulse per bit time; the line is sampled on it |
| serialIn | input | 1 | Serial receive line, idle high |
| readReq | input | 1 | Pop the oldest entry onto the outputs |
| dataOut | output | 9 | Parity bit in [8], data byte in [7:0] of the last popped entry |
| errOut | output | 3 | Break [2], overrun [1], frame [0] of the last popped entry |
| emptyFlag | output | 1 | No entries stored |
| readyFlag | output | 1 | Store can accept another frame |

## Verification
A frame can complete on the stop sample in the same cycle that a read pops an entry. This matters most when the store is full, because the outcome decides between storing the frame and discarding it as an overrun. The bench fills all eight slots, then raises the read command exactly on the tick that samples the stop bit. It judges the result by reading out the whole store: the oldest word must come back first, the new frame must appear last, and no entry may carry the overrun flag. A second run without the overlapping read must drop the frame and mark the newest entry instead.

// File: rtl/rx_err_fifo_pkg.sv
package rx_err_fifo_pkg;
  localparam int DATA_W  = 8;
  localparam int ERR_W   = 3;
  localparam int ENTRY_W = DATA_W + 1 + ERR_W;

  typedef struct packed {
    logic              brk;
    logic              ovr;
    logic              frm;
    logic              par;
    logic [DATA_W-1:0] data;
  } entry_t;

  typedef struct packed {
    logic push;
    logic markOverrun;
    logic pop;
  } strobe_t;
endpackage

// File: rtl/rx_frame_ctrl.sv
module rx_frame_ctrl
  import rx_err_fifo_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    baudTick,
  input  logic    serialIn,
  input  logic    readReq,
  input  logic    fifoFull,
  input  logic    fifoEmpty,
  output strobe_t strobes,
  output entry_t  newEntry
);
  localparam int CNT_W = $clog2(DATA_W + 1);

  typedef enum logic [1:0] {S_IDLE, S_BITS, S_STOP} rx_state_t;

  rx_state_t       state;
  logic [CNT_W-1:0] bitCnt;
  logic [DATA_W:0]  shReg;
  logic             frameDone;

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= S_IDLE;
      bitCnt <= '0;
      shReg  <= '0;
    end else if (baudTick) begin
      case (state)
        S_IDLE: begin
          if (!serialIn) begin
            state  <= S_BITS;
            bitCnt <= '0;
          end
        end
        S_BITS: begin
          shReg <= {serialIn, shReg[DATA_W:1]};
          if (bitCnt == CNT_W'(DATA_W)) state <= S_STOP;
          else bitCnt <= bitCnt + CNT_W'(1);
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    frameDone        = baudTick && (state == S_STOP);
    newEntry.data    = shReg[DATA_W-1:0];
    newEntry.par     = shReg[DATA_W];
    newEntry.frm     = !serialIn;
    newEntry.brk     = !serialIn && (shReg == '0);
    newEntry.ovr     = 1'b0;
    strobes.pop      = readReq && !fifoEmpty;
    strobes.push     = frameDone && (!fifoFull || strobes.pop);
    strobes.markOverrun = frameDone && fifoFull && !strobes.pop;
  end
endmodule

// File: rtl/rx_fifo_store.sv
module rx_fifo_store
  import rx_err_fifo_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  strobe_t           strobes,
  input  entry_t            newEntry,
  output logic [DATA_W:0]   dataOut,
  output logic [ERR_W-1:0]  errOut,
  output logic              fifoFull,
  output logic              fifoEmpty
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  entry_t           mem [DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr, newestIdx;
  logic [CNT_W-1:0] count;

  function automatic logic [PTR_W-1:0] nextPtr(input logic [PTR_W-1:0] p);
    return (p == LAST) ? '0 : p + PTR_W'(1);
  endfunction

  always_comb begin
    fifoFull  = (count == CNT_W'(DEPTH));
    fifoEmpty = (count == '0);
    newestIdx = (wrPtr == '0) ? LAST : wrPtr - PTR_W'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (strobes.push) begin
      mem[wrPtr] <= newEntry;
    end else if (strobes.markOverrun) begin
      mem[newestIdx].ovr <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wrPtr   <= '0;
      rdPtr   <= '0;
      count   <= '0;
      dataOut <= '0;
      errOut  <= '0;
    end else begin
      if (strobes.push) wrPtr <= nextPtr(wrPtr);
      if (strobes.pop) begin
        rdPtr   <= nextPtr(rdPtr);
        dataOut <= {mem[rdPtr].par, mem[rdPtr].data};
        errOut  <= {mem[rdPtr].brk, mem[rdPtr].ovr, mem[rdPtr].frm};
      end
      case ({strobes.push, strobes.pop})
        2'b10:   count <= count + CNT_W'(1);
        2'b01:   count <= count - CNT_W'(1);
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/rx_err_fifo.sv
module rx_err_fifo
  import rx_err_fifo_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             baudTick,
  input  logic             serialIn,
  input  logic             readReq,
  output logic [DATA_W:0]  dataOut,
  output logic [ERR_W-1:0] errOut,
  output logic             emptyFlag,
  output logic             readyFlag
);
  strobe_t strobes;
  entry_t  newEntry;
  logic    fifoFull, fifoEmpty;

  rx_frame_ctrl u_ctrl (
    .clk(clk), .rst(rst), .baudTick(baudTick), .serialIn(serialIn),
    .readReq(readReq), .fifoFull(fifoFull), .fifoEmpty(fifoEmpty),
    .strobes(strobes), .newEntry(newEntry)
  );

  rx_fifo_store #(.DEPTH(DEPTH)) u_store (
    .clk(clk), .rst(rst), .strobes(strobes), .newEntry(newEntry),
    .dataOut(dataOut), .errOut(errOut),
    .fifoFull(fifoFull), .fifoEmpty(fifoEmpty)
  );

  assign emptyFlag = fifoEmpty;
  assign readyFlag = !fifoFull;
endmodule

// File: rtl/rx_err_fifo_chk.sv
module rx_err_fifo_chk (
  input logic       clk,
  input logic       rst,
  input logic       baudTick,
  input logic       readReq,
  input logic [8:0] dataOut,
  input logic [2:0] errOut,
  input logic       emptyFlag,
  input logic       readyFlag
);
  assert_reset_state_R1: assert property (@(posedge clk)
    rst |=> (emptyFlag && readyFlag && dataOut == '0 && errOut == '0));

  assert_break_has_frame_R4: assert property (@(posedge clk) disable iff (rst)
    errOut[2] |-> errOut[0]);

  assert_out_hold_R5: assert property (@(posedge clk) disable iff (rst)
    !readReq |=> ($stable(dataOut) && $stable(errOut)));

  assert_flags_exclusive_R6: assert property (@(posedge clk) disable iff (rst)
    !(emptyFlag && !readyFlag));

  assert_full_stays_R7: assert property (@(posedge clk) disable iff (rst)
    (!readyFlag && !readReq) |=> !readyFlag);

  assert_empty_read_R8: assert property (@(posedge clk) disable iff (rst)
    (readReq && emptyFlag) |=> ($stable(dataOut) && $stable(errOut) && emptyFlag));

  assert_no_tick_no_push_R10: assert property (@(posedge clk) disable iff (rst)
    (!baudTick && !readReq) |=> ($stable(emptyFlag) && $stable(readyFlag)));
endmodule

bind rx_err_fifo rx_err_fifo_chk u_chk (
  .clk(clk), .rst(rst), .baudTick(baudTick), .readReq(readReq),
  .dataOut(dataOut), .errOut(errOut), .emptyFlag(emptyFlag), .readyFlag(readyFlag)
);

// File: tb/tb_rx_err_fifo.sv
module tb_rx_err_fifo;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       baudTick = 1'b0;
  logic       serialIn = 1'b1;
  logic       readReq = 1'b0;
  logic [8:0] dataOut;
  logic [2:0] errOut;
  logic       emptyFlag, readyFlag;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  rx_err_fifo dut (
    .clk(clk), .rst(rst), .baudTick(baudTick), .serialIn(serialIn),
    .readReq(readReq), .dataOut(dataOut), .errOut(errOut),
    .emptyFlag(emptyFlag), .readyFlag(readyFlag)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // vector fields: {expErr[12:10], stop[9], parity[8], data[7:0]}
  localparam logic [12:0] VECS [7] = '{
    {3'b000, 1'b1, 1'b1, 8'hA5},
    {3'b000, 1'b1, 1'b0, 8'h3C},
    {3'b000, 1'b1, 1'b1, 8'h00},
    {3'b001, 1'b0, 1'b0, 8'h81},
    {3'b101, 1'b0, 1'b0, 8'h00},
    {3'b000, 1'b1, 1'b1, 8'hFF},
    {3'b000, 1'b1, 1'b0, 8'h00}
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tickBit(input logic b, input logic rd);
    @(negedge clk);
    serialIn = b;
    baudTick = 1'b1;
    readReq  = rd;
    @(negedge clk);
    baudTick = 1'b0;
    readReq  = 1'b0;
  endtask

  task automatic sendFrame(input logic [7:0] d, input logic p, input logic s, input logic rdOnStop);
    tickBit(1'b0, 1'b0);
    for (int i = 0; i < 8; i++) tickBit(d[i], 1'b0);
    tickBit(p, 1'b0);
    tickBit(s, rdOnStop);
    serialIn = 1'b1;
  endtask

  task automatic doRead();
    @(negedge clk);
    readReq = 1'b1;
    @(negedge clk);
    readReq = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 empty", 16'(emptyFlag), 16'd1);
    chk("R1 ready", 16'(readyFlag), 16'd1);
    chk("R1 dataOut", 16'(dataOut), 16'd0);
    chk("R1 errOut", 16'(errOut), 16'd0);
    rst = 1'b0;
    @(negedge clk);

    // R8 read while empty
    doRead();
    chk("R8 dataOut held", 16'(dataOut), 16'd0);
    chk("R8 errOut held", 16'(errOut), 16'd0);
    chk("R8 still empty", 16'(emptyFlag), 16'd1);
    chk("R8 ready held", 16'(readyFlag), 16'd1);

    // R10 line activity without ticks, ticks sampling idle high
    @(negedge clk); serialIn = 1'b0;
    repeat (5) @(negedge clk);
    serialIn = 1'b1;
    for (int i = 0; i < 12; i++) tickBit(1'b1, 1'b0);
    chk("R10 nothing stored", 16'(emptyFlag), 16'd1);

    // table of frames: R2 R3 R4
    for (int v = 0; v < 7; v++) begin
      sendFrame(VECS[v][7:0], VECS[v][8], VECS[v][9], 1'b0);
      chk("R2 stored not empty", 16'(emptyFlag), 16'd0);
      doRead();
      chk("R2 dataOut", 16'(dataOut), 16'(VECS[v][8:0]));
      chk("R3/R4 errOut", 16'(errOut), 16'(VECS[v][12:10]));
    end
    chk("R6 empty after drain", 16'(emptyFlag), 16'd1);

    // fill to full, then overrun: R5 R6 R7
    for (int i = 0; i < 8; i++) begin
      sendFrame(8'(i * 17 + 1), i[0], 1'b1, 1'b0);
      if (i == 6) chk("R6 ready at 7", 16'(readyFlag), 16'd1);
    end
    chk("R6 ready low when full", 16'(readyFlag), 16'd0);
    chk("R6 not empty when full", 16'(emptyFlag), 16'd0);
    sendFrame(8'hEE, 1'b1, 1'b1, 1'b0);
    chk("R7 still full", 16'(readyFlag), 16'd0);
    for (int i = 0; i < 8; i++) begin
      doRead();
      chk("R5 order", 16'(dataOut), 16'({i[0], 8'(i * 17 + 1)}));
      chk("R7 overrun on newest", 16'(errOut), (i == 7) ? 16'd2 : 16'd0);
      if (i == 0) chk("R6 ready after pop", 16'(readyFlag), 16'd1);
    end
    chk("R7 dropped frame absent", 16'(emptyFlag), 16'd1);

    // same-cycle completion and read on full store: R9
    for (int i = 0; i < 8; i++) sendFrame(8'(8'h10 + i), 1'b0, 1'b1, 1'b0);
    sendFrame(8'h77, 1'b1, 1'b1, 1'b1);
    chk("R9 oldest popped", 16'(dataOut), 16'h010);
    chk("R9 no error on popped", 16'(errOut), 16'd0);
    chk("R9 still full", 16'(readyFlag), 16'd0);
    for (int i = 1; i < 9; i++) begin
      doRead();
      chk("R9 contents", 16'(dataOut), (i == 8) ? 16'h177 : 16'(8'h10 + i));
      chk("R9 no overrun", 16'(errOut), 16'd0);
    end
    chk("R9 empty after drain", 16'(emptyFlag), 16'd1);

    // reset discards contents: R1
    sendFrame(8'h5A, 1'b0, 1'b1, 1'b0);
    chk("R1 stored before reset", 16'(emptyFlag), 16'd0);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    chk("R1 empty after reset", 16'(emptyFlag), 16'd1);
    doRead();
    chk("R1 nothing to read", 16'(dataOut), 16'd0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule